// File: doc/BRIEF.md
# Parallel Flash Host Bus Front End

This block sits between an asynchronous parallel flash bus and the internals of a flash model. The chip enable, output enable and write enable strobes are active low and arrive with no relation to the system clock. The block oversamples them through two-flop synchronizers. The address and write data buses pass through delay pipes of the same depth, so that every bus sample stays aligned with the strobe levels it belongs to.

A read cycle turns the data bus driver on and presents the word that the array returns for the current address. A write cycle can be strobed by either chip enable or write enable. The block takes the address at the later of the two falling edges and the data at the earlier of the two rising edges. It then hands a command decoder a one-cycle pulse that carries the latched address, the low data byte and a region code.

A region decoder sorts addresses into boot, parameter and main areas. Its layout is set by a parameter: boot block at the bottom of the space, or at the top as a mirror image. The decoder also classifies the live address continuously.

Top module: `pflash_bus_front`

## Requirements
- R1: When chip enable and output enable are both low and write enable is high, `dq_oe_o` rises two clock edges after the strobes settle, and `dq_o` carries `array_rdata_i` for the present address.
- R2: Whenever the synchronized chip enable or output enable is high, `dq_oe_o` is low and `dq_o` is all zeros.
- R3: For a write strobed by write enable, with chip enable already low, the address forwarded is the one present when write enable falls (the later falling edge). Address changes before that edge and after it are not forwarded.
- R4: For a write strobed by chip enable, with write enable already low, the data forwarded is the value present when the first strobe rises. Data changes after that edge are not forwarded.
- R5: Each completed write yields exactly one `cmd_valid_o` pulse, one clock wide.
- R6: Only bits 7:0 of the write data appear on `cmd_code_o`. Bits 15:8 have no effect.
- R7: A write in which output enable is low at any time while both strobes are low produces no `cmd_valid_o` pulse.
- R8: During reset and on the first edge after it, `dq_oe_o` and `cmd_valid_o` are low. With read levels held on the pins through reset, `dq_oe_o` goes high on the second edge after release.
- R9: With the bottom layout and a 20-bit byte address, the region codes are: 11 (boot) for 0x00000-0x03FFF, 01 (parameter 1) for 0x04000-0x05FFF, 10 (parameter 2) for 0x06000-0x07FFF, and 00 (main) for 0x08000-0xFFFFF. `addr_region_o` shows the code for the live address.
- R10: With the top layout, the codes are: 11 for 0xFC000-0xFFFFF, 01 for 0xFA000-0xFBFFF, 10 for 0xF8000-0xF9FFF, and 00 for 0x00000-0xF7FFF.
- R11: `cmd_region_o` holds the region code of the latched write address for the duration of the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n_i | input | 1 | Chip enable, active low, asynchronous |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| we_n_i | input | 1 | Write enable, active low, asynchronous |
| addr_i | input | ADDR_W | Bus address |
| wdata_i | input | DATA_W | Bus write data |
| array_rdata_i | input | DATA_W | Word returned by the array for `addr_i` |
| dq_o | output | DATA_W | Read data driven toward the bus |
| dq_oe_o | output | 1 | Bus driver enable; low means high impedance |
| addr_region_o | output | 2 | Region code of the live address |
| cmd_valid_o | output | 1 | One-cycle pulse per completed write |
| cmd_addr_o | output | ADDR_W | Latched write address |
| cmd_code_o | output | 8 | Latched low byte of write data |
| cmd_region_o | output | 2 | Region code of the latched address |

## Verification
The write path is tried with both strobe orders: chip enable first with write enable as the strobe, and the reverse. Each order is paired with an address that changes before the later falling edge, and with data that changes between the first and the second rising edge. A wrong choice of latching edge therefore shows up as a wrong address or a wrong code byte.

The write data carries distinct upper bytes, which exposes any leak of bits 15:8. Writes with output enable low from the start, and writes where it drops in the middle, separate a rejected write from an accepted one. Region probes sit on both sides of every boundary in both layouts, which catches off-by-one limits and a mirror applied the wrong way round.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  typedef enum logic [1:0] {
    REG_MAIN = 2'b00,
    REG_PAR1 = 2'b01,
    REG_PAR2 = 2'b10,
    REG_BOOT = 2'b11
  } region_e;

  typedef enum logic [1:0] {
    WR_IDLE = 2'b00,
    WR_OPEN = 2'b01,
    WR_VOID = 2'b10
  } wr_state_e;

endpackage

// File: rtl/pfb_sync_pipe.sv
module pfb_sync_pipe #(
  parameter int   WIDTH     = 1,
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_head
      assign stage_d = d_i;
    end else begin : g_tail
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= {WIDTH{RESET_VAL}};
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pfb_region.sv
module pfb_region
  import pfb_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o
);

  localparam logic [ADDR_W-1:0] ONE      = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] LIM_BOOT = ONE << (ADDR_W - 6);
  localparam logic [ADDR_W-1:0] LIM_PAR1 = LIM_BOOT + (LIM_BOOT >> 1);
  localparam logic [ADDR_W-1:0] LIM_PAR2 = LIM_BOOT << 1;

  logic [ADDR_W-1:0] offset;

  // top layout is the bottom layout seen through an inverted address
  if (TOP_BOOT) begin : g_top
    assign offset = ~addr_i;
  end else begin : g_bottom
    assign offset = addr_i;
  end

  always_comb begin
    if (offset < LIM_BOOT) begin
      region_o = REG_BOOT;
    end else if (offset < LIM_PAR1) begin
      region_o = REG_PAR1;
    end else if (offset < LIM_PAR2) begin
      region_o = REG_PAR2;
    end else begin
      region_o = REG_MAIN;
    end
  end

endmodule

// File: rtl/pfb_write_capture.sv
module pfb_write_capture
  import pfb_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s_i,
  input  logic              we_s_i,
  input  logic              oe_s_i,
  input  logic [ADDR_W-1:0] addr_d_i,
  input  logic [7:0]        code_d_i,
  input  region_e           region_d_i,
  output logic              cmd_valid_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [7:0]        cmd_code_o,
  output region_e           cmd_region_o
);

  wr_state_e         state_q, state_d;
  logic              strobe_low;
  logic              ld_addr;
  logic              fire;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        code_q;
  region_e           region_q;
  logic              valid_q;

  assign strobe_low = !ce_s_i && !we_s_i;

  always_comb begin
    state_d = state_q;
    ld_addr = 1'b0;
    fire    = 1'b0;
    unique case (state_q)
      WR_IDLE: begin
        if (strobe_low) begin
          if (oe_s_i) begin
            state_d = WR_OPEN;
            ld_addr = 1'b1;
          end else begin
            state_d = WR_VOID;
          end
        end
      end
      WR_OPEN: begin
        if (!strobe_low) begin
          state_d = WR_IDLE;
          fire    = 1'b1;
        end else if (!oe_s_i) begin
          state_d = WR_VOID;
        end
      end
      WR_VOID: begin
        if (!strobe_low) begin
          state_d = WR_IDLE;
        end
      end
      default: state_d = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WR_IDLE;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      region_q <= REG_MAIN;
    end else if (ld_addr) begin
      addr_q   <= addr_d_i;
      region_q <= region_d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (fire) begin
      code_q <= code_d_i;
    end
  end

  assign cmd_valid_o  = valid_q;
  assign cmd_addr_o   = addr_q;
  assign cmd_code_o   = code_q;
  assign cmd_region_o = region_q;

  assert_single_pulse_R5 : assert property (
    @(posedge clk) disable iff (!rst_n) cmd_valid_o |=> !cmd_valid_o);

  assert_void_silent_R7 : assert property (
    @(posedge clk) disable iff (!rst_n) (state_q == WR_VOID) |=> !cmd_valid_o);

  // R4: a pulse only follows a strobe release
  assert_pulse_after_release_R4 : assert property (
    @(posedge clk) disable iff (!rst_n) cmd_valid_o |-> !(!ce_s_i && !we_s_i));

endmodule

// File: rtl/pflash_bus_front.sv
module pflash_bus_front
  import pfb_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit TOP_BOOT    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] array_rdata_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [1:0]        addr_region_o,
  output logic              cmd_valid_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [7:0]        cmd_code_o,
  output logic [1:0]        cmd_region_o
);

  localparam int CODE_W = 8;
  localparam int BUS_W  = ADDR_W + CODE_W;

  logic [2:0]        strobe_raw, strobe_s;
  logic              ce_s, oe_s, we_s;
  logic [BUS_W-1:0]  bus_raw, bus_d;
  logic [ADDR_W-1:0] addr_d;
  logic [7:0]        code_d;
  logic              unused_hi_byte;
  region_e           live_region, pipe_region, cmd_region;
  logic              read_on;

  assign strobe_raw = {ce_n_i, oe_n_i, we_n_i};

  pfb_sync_pipe #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)
  ) i_strobe_sync (
    .clk(clk), .rst_n(rst_n), .d_i(strobe_raw), .q_o(strobe_s)
  );

  assign ce_s = strobe_s[2];
  assign oe_s = strobe_s[1];
  assign we_s = strobe_s[0];

  // bus delayed by the same depth to stay aligned with the strobes
  assign bus_raw        = {addr_i, wdata_i[CODE_W-1:0]};
  assign unused_hi_byte = ^wdata_i[DATA_W-1:CODE_W];

  pfb_sync_pipe #(
    .WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)
  ) i_bus_delay (
    .clk(clk), .rst_n(rst_n), .d_i(bus_raw), .q_o(bus_d)
  );

  assign addr_d = bus_d[BUS_W-1:CODE_W];
  assign code_d = bus_d[CODE_W-1:0];

  pfb_region #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) i_live_region (
    .addr_i(addr_i), .region_o(live_region)
  );

  pfb_region #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) i_pipe_region (
    .addr_i(addr_d), .region_o(pipe_region)
  );

  pfb_write_capture #(.ADDR_W(ADDR_W)) i_capture (
    .clk(clk), .rst_n(rst_n),
    .ce_s_i(ce_s), .we_s_i(we_s), .oe_s_i(oe_s),
    .addr_d_i(addr_d), .code_d_i(code_d), .region_d_i(pipe_region),
    .cmd_valid_o(cmd_valid_o), .cmd_addr_o(cmd_addr_o),
    .cmd_code_o(cmd_code_o), .cmd_region_o(cmd_region)
  );

  assign read_on       = !ce_s && !oe_s && we_s;
  assign dq_oe_o       = read_on;
  assign dq_o          = read_on ? array_rdata_i : '0;
  assign addr_region_o = live_region;
  assign cmd_region_o  = cmd_region;

  assert_hiz_when_deselected_R2 : assert property (
    @(posedge clk) disable iff (!rst_n)
      ($past(ce_n_i, 2) || $past(oe_n_i, 2)) |-> (!dq_oe_o && (dq_o == '0)));

  assert_quiet_after_reset_R8 : assert property (
    @(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (!dq_oe_o && !cmd_valid_o));

endmodule

// File: tb/test_pflash_bus_front.sv
module test_pflash_bus_front;

  typedef struct packed {
    logic        ce_strobe;
    logic [19:0] a_first;
    logic [19:0] a_last;
    logic [15:0] data;
    logic [1:0]  exp_region;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 20'h12345, 20'h00555, 16'hAB5A, 2'b11},
    '{1'b1, 20'h00001, 20'h04000, 16'h1234, 2'b01},
    '{1'b0, 20'hF0F0F, 20'h07FFF, 16'hFFC3, 2'b10},
    '{1'b1, 20'h0ABCD, 20'h08000, 16'h00F0, 2'b00},
    '{1'b0, 20'h80000, 20'h03FFF, 16'h7E01, 2'b11},
    '{1'b1, 20'h00000, 20'hFFFFF, 16'h5599, 2'b00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] dq;
  logic        dq_oe, cmd_valid;
  logic [19:0] cmd_addr;
  logic [7:0]  cmd_code;
  logic [1:0]  region_bot, region_top, cmd_region;
  logic [15:0] m_dq;
  logic        m_oe, m_valid;
  logic [19:0] m_addr;
  logic [7:0]  m_code;
  logic [1:0]  m_region;

  int n_tests = 0, n_fail = 0;
  int pulses = 0, run_len = 0, max_run = 0;
  logic [19:0] got_addr;
  logic [7:0]  got_code;
  logic [1:0]  got_region;

  always #10 clk = ~clk;

  function automatic logic [15:0] stub_word(input logic [19:0] a);
    return {a[7:0], a[15:8] ^ 8'hC3};
  endfunction

  assign rdata = stub_word(addr);

  pflash_bus_front i_pflash_bus_front (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .addr_i(addr), .wdata_i(wdata), .array_rdata_i(rdata),
    .dq_o(dq), .dq_oe_o(dq_oe), .addr_region_o(region_bot),
    .cmd_valid_o(cmd_valid), .cmd_addr_o(cmd_addr),
    .cmd_code_o(cmd_code), .cmd_region_o(cmd_region)
  );

  pflash_bus_front #(.TOP_BOOT(1'b1)) i_pflash_bus_front_mirror (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .addr_i(addr), .wdata_i(wdata), .array_rdata_i(rdata),
    .dq_o(m_dq), .dq_oe_o(m_oe), .addr_region_o(region_top),
    .cmd_valid_o(m_valid), .cmd_addr_o(m_addr),
    .cmd_code_o(m_code), .cmd_region_o(m_region)
  );

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (cmd_valid) begin
      pulses   = pulses + 1;
      run_len  = run_len + 1;
      got_addr = cmd_addr;
      got_code = cmd_code;
      got_region = cmd_region;
      if (run_len > max_run) max_run = run_len;
    end else begin
      run_len = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_mon();
    pulses = 0; max_run = 0;
  endtask

  task automatic run_write(input vec_t v);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    addr = v.a_first; wdata = 16'h0000;
    ticks(4);
    clear_mon();
    if (v.ce_strobe) we_n = 1'b0; else ce_n = 1'b0;
    ticks(4);
    addr = v.a_last; wdata = v.data;
    if (v.ce_strobe) ce_n = 1'b0; else we_n = 1'b0;
    ticks(5);
    addr = v.a_first;
    ticks(3);
    if (v.ce_strobe) ce_n = 1'b1; else we_n = 1'b1;
    ticks(1);
    wdata = ~v.data;
    ticks(4);
    if (v.ce_strobe) we_n = 1'b1; else ce_n = 1'b1;
    ticks(8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R5 watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R8: reset with read levels already on the pins
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 20'h01234;
    ticks(3);
    chk("R8 oe in reset", {31'd0, dq_oe}, 32'd0);
    chk("R8 valid in reset", {31'd0, cmd_valid}, 32'd0);
    rst_n = 1'b1;
    ticks(1);
    chk("R8 oe first edge", {31'd0, dq_oe}, 32'd0);
    ticks(1);
    chk("R8 oe second edge", {31'd0, dq_oe}, 32'd1);
    chk("R1 read data", {16'd0, dq}, {16'd0, stub_word(20'h01234)});

    // table of writes: R3 address edge, R4 data edge, R5 pulse, R6 byte, R11 region
    for (int k = 0; k < NVEC; k++) begin
      run_write(VECS[k]);
      chk("R5 pulse count", pulses, 32'd1);
      chk("R5 pulse width", max_run, 32'd1);
      chk("R3 latched address", {12'd0, got_addr}, {12'd0, VECS[k].a_last});
      chk("R4 R6 latched code", {24'd0, got_code}, {24'd0, VECS[k].data[7:0]});
      chk("R11 region", {30'd0, got_region}, {30'd0, VECS[k].exp_region});
    end

    // R1 read after writes, different address
    addr = 20'h5A5A5; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    ticks(3);
    chk("R1 read enable", {31'd0, dq_oe}, 32'd1);
    chk("R1 read data 2", {16'd0, dq}, {16'd0, stub_word(20'h5A5A5)});
    // R2 output enable high
    oe_n = 1'b1;
    ticks(3);
    chk("R2 oe high enable", {31'd0, dq_oe}, 32'd0);
    chk("R2 oe high data", {16'd0, dq}, 32'd0);
    // R2 chip enable high
    oe_n = 1'b0; ce_n = 1'b1;
    ticks(3);
    chk("R2 ce high enable", {31'd0, dq_oe}, 32'd0);
    chk("R2 ce high data", {16'd0, dq}, 32'd0);
    oe_n = 1'b1;
    ticks(3);

    // R7: output enable low throughout a write
    clear_mon();
    oe_n = 1'b0; ce_n = 1'b0; ticks(4);
    we_n = 1'b0; wdata = 16'h0011; ticks(5);
    we_n = 1'b1; ticks(4); ce_n = 1'b1; oe_n = 1'b1; ticks(8);
    chk("R7 oe low whole write", pulses, 32'd0);

    // R7: output enable drops in the middle of a write
    clear_mon();
    ce_n = 1'b0; ticks(4);
    we_n = 1'b0; wdata = 16'h0022; ticks(5);
    oe_n = 1'b0; ticks(4); oe_n = 1'b1; ticks(3);
    we_n = 1'b1; ticks(4); ce_n = 1'b1; ticks(8);
    chk("R7 oe low mid write", pulses, 32'd0);

    // R5 R6: a normal write still works afterwards, high byte ignored
    run_write('{1'b0, 20'h00000, 20'h06000, 16'hE7A9, 2'b10});
    chk("R5 write after reject", pulses, 32'd1);
    chk("R6 high byte ignored", {24'd0, got_code}, 32'h000000A9);

    // R9 bottom layout boundaries
    addr = 20'h00000; #1; chk("R9 0x00000", {30'd0, region_bot}, 32'd3);
    addr = 20'h03FFF; #1; chk("R9 0x03FFF", {30'd0, region_bot}, 32'd3);
    addr = 20'h04000; #1; chk("R9 0x04000", {30'd0, region_bot}, 32'd1);
    addr = 20'h05FFF; #1; chk("R9 0x05FFF", {30'd0, region_bot}, 32'd1);
    addr = 20'h06000; #1; chk("R9 0x06000", {30'd0, region_bot}, 32'd2);
    addr = 20'h07FFF; #1; chk("R9 0x07FFF", {30'd0, region_bot}, 32'd2);
    addr = 20'h08000; #1; chk("R9 0x08000", {30'd0, region_bot}, 32'd0);
    addr = 20'hFFFFF; #1; chk("R9 0xFFFFF", {30'd0, region_bot}, 32'd0);
    // R10 top layout boundaries
    addr = 20'hFFFFF; #1; chk("R10 0xFFFFF", {30'd0, region_top}, 32'd3);
    addr = 20'hFC000; #1; chk("R10 0xFC000", {30'd0, region_top}, 32'd3);
    addr = 20'hFBFFF; #1; chk("R10 0xFBFFF", {30'd0, region_top}, 32'd1);
    addr = 20'hFA000; #1; chk("R10 0xFA000", {30'd0, region_top}, 32'd1);
    addr = 20'hF9FFF; #1; chk("R10 0xF9FFF", {30'd0, region_top}, 32'd2);
    addr = 20'hF8000; #1; chk("R10 0xF8000", {30'd0, region_top}, 32'd2);
    addr = 20'hF7FFF; #1; chk("R10 0xF7FFF", {30'd0, region_top}, 32'd0);
    addr = 20'h00000; #1; chk("R10 0x00000", {30'd0, region_top}, 32'd0);

    ticks(2);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule